// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Invalidation

This block caches virtual-to-physical page translations in a small fully associative table. Every entry stores a virtual page number, a physical frame number, its own page-size exponent, an address-space identifier, a global flag, a valid bit and a 10-bit attribute word. The attribute word is carried through unchanged and holds domain, permission, execute-never, section flag and non-cacheable bits. A lookup is purely combinational: it takes a virtual address and an identifier, and in the same cycle it returns a hit flag, the index of the matching entry, the translated physical address and that entry's attributes.

Refills arrive on an insert port. A round-robin victim pointer picks the slot that an insert overwrites. A lookup that hits the slot the pointer currently names pushes the pointer on by one, so a freshly used entry is not the next to be replaced. A maintenance port removes entries in four ways: all of them, by identifier, by address containment, or by address together with identifier. Each operation takes one clock edge.

Top module: `tlb_fa`

## Requirements
- R1: An insert writes the slot named by the victim pointer and sets it valid. The pointer then advances by one and wraps from ENTRIES-1 to 0.
- R2: An entry matches a lookup when it is valid, (va >> shift) equals its stored page number, and either its global flag is set or its identifier equals the lookup identifier. When several entries match, the lowest index wins. The block reports that index and the entry's attribute word.
- R3: The physical address is (frame << shift) OR'd with the virtual address bits below bit `shift`. This holds for any per-entry shift, for example 12 or 20.
- R4: When lkReq is high and the lookup hits the slot the victim pointer names, the pointer advances by one. A hit on any other slot leaves the pointer unchanged.
- R5: mntOp=0 (invalidate all) clears every valid bit and resets the victim pointer to 0.
- R6: mntOp=1 clears every entry whose stored identifier equals mntId, whatever its address.
- R7: mntOp=2 clears every entry whose range contains mntAddr, ignoring the stored identifier. The range runs from vpn<<shift and is 2^shift bytes long.
- R8: mntOp=3 clears every entry that a lookup with mntAddr and mntId would hit, global entries included. All such entries are cleared together.
- R9: A lookup in the same cycle as a maintenance operation sees the contents before the operation. An insert in the same cycle as an invalidation survives it.
- R10: After reset no entry is valid, no lookup hits and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lkReq | input | 1 | Lookup counts as a use (allows victim-pointer skip) |
| lkVa | input | VA_W | Lookup virtual address |
| lkId | input | ID_W | Lookup identifier |
| lkHit | output | 1 | Lookup hit |
| lkIdx | output | IDX_W | Index of matching entry |
| lkPa | output | PA_W | Translated physical address |
| lkAttr | output | 10 | Attribute word of matching entry |
| insValid | input | 1 | Insert strobe |
| insVpn | input | VA_W | Page number (address >> shift) |
| insPfn | input | PA_W | Frame number |
| insShift | input | SHIFT_W | Page-size exponent |
| insId | input | ID_W | Identifier of the new entry |
| insGlobal | input | 1 | Entry matches any identifier |
| insAttr | input | 10 | Attribute word |
| mntValid | input | 1 | Maintenance strobe |
| mntOp | input | 2 | 0 all, 1 by id, 2 by address, 3 by address and id |
| mntAddr | input | VA_W | Maintenance address |
| mntId | input | ID_W | Maintenance identifier |

## Verification
The victim pointer cannot be seen at the ports, and it is the hardest state to steer. The bench fixes its position by counting inserts exactly, including one full wrap of the table. It then reads the pointer back indirectly: it inserts a unique page and checks the index that a lookup of that page reports. The skip-on-hit rule is tested the same way, once with a requested lookup on the pointed slot and once with a lookup on a different slot. Same-cycle cases are also driven: a lookup during an invalidation, and an insert during invalidate-all.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int ATTR_W = 10;

  typedef enum logic [1:0] {
    MNT_ALL     = 2'd0,
    MNT_BY_ID   = 2'd1,
    MNT_BY_ADDR = 2'd2,
    MNT_BY_BOTH = 2'd3
  } mnt_op_e;

  typedef struct packed {
    logic doWrite;
    logic clrAll;
    logic clrById;
    logic clrByAddr;
    logic clrByBoth;
  } tlb_strobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkReq,
  input  logic             lkHit,
  input  logic [IDX_W-1:0] lkIdx,
  input  logic             insValid,
  input  logic             mntValid,
  input  logic [1:0]       mntOp,
  output tlb_strobe_t      stb,
  output logic [IDX_W-1:0] victimPtr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] ptrInc;
  logic             stepPtr;
  mnt_op_e          opSel;

  assign opSel = mnt_op_e'(mntOp);

  always_comb begin
    stb           = '0;
    stb.doWrite   = insValid;
    stb.clrAll    = mntValid && (opSel == MNT_ALL);
    stb.clrById   = mntValid && (opSel == MNT_BY_ID);
    stb.clrByAddr = mntValid && (opSel == MNT_BY_ADDR);
    stb.clrByBoth = mntValid && (opSel == MNT_BY_BOTH);
  end

  assign ptrInc  = (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
  assign stepPtr = insValid || (lkReq && lkHit && (lkIdx == ptrQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            ptrQ <= '0;
    else if (stb.clrAll)  ptrQ <= '0;
    else if (stepPtr)     ptrQ <= ptrInc;
  end

  assign victimPtr = ptrQ;

  AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= LAST); // R1
  AST_PTR_AFTER_INSERT: assert property (@(posedge clk) disable iff (!rstN)
    (insValid && !stb.clrAll) |=>
      ptrQ == (($past(ptrQ) == LAST) ? '0 : $past(ptrQ) + 1'b1)); // R1
  AST_PTR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> ptrQ == '0); // R5
  AST_PTR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!mntValid && !insValid && !(lkReq && lkHit)) |=> $stable(ptrQ)); // R4
endmodule

// File: rtl/tlb_dpath.sv
module tlb_dpath
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ID_W    = 8,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int SHIFT_W = $clog2(VA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlb_strobe_t        stb,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [VA_W-1:0]    lkVa,
  input  logic [ID_W-1:0]    lkId,
  output logic               lkHit,
  output logic [IDX_W-1:0]   lkIdx,
  output logic [PA_W-1:0]    lkPa,
  output logic [ATTR_W-1:0]  lkAttr,
  input  logic [VA_W-1:0]    insVpn,
  input  logic [PA_W-1:0]    insPfn,
  input  logic [SHIFT_W-1:0] insShift,
  input  logic [ID_W-1:0]    insId,
  input  logic               insGlobal,
  input  logic [ATTR_W-1:0]  insAttr,
  input  logic [VA_W-1:0]    mntAddr,
  input  logic [ID_W-1:0]    mntId
);
  logic [VA_W-1:0]    vpnQ   [ENTRIES];
  logic [PA_W-1:0]    pfnQ   [ENTRIES];
  logic [SHIFT_W-1:0] shQ    [ENTRIES];
  logic [ID_W-1:0]    idQ    [ENTRIES];
  logic [ATTR_W-1:0]  attrQ  [ENTRIES];
  logic [ENTRIES-1:0] globQ;
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] clrVec;
  logic [ENTRIES-1:0] wrVec;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    logic addrIn;
    logic idSame;

    assign lkMatch[i] = validQ[i] && ((lkVa >> shQ[i]) == vpnQ[i]) &&
                        (globQ[i] || (idQ[i] == lkId));
    assign addrIn     = (mntAddr >> shQ[i]) == vpnQ[i];
    assign idSame     = idQ[i] == mntId;
    assign clrVec[i]  = stb.clrAll || (stb.clrById && idSame) ||
                        (stb.clrByAddr && addrIn) ||
                        (stb.clrByBoth && addrIn && (globQ[i] || idSame));
    assign wrVec[i]   = stb.doWrite && (wrIdx == IDX_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ[i] <= 1'b0;
        globQ[i]  <= 1'b0;
        vpnQ[i]   <= '0;
        pfnQ[i]   <= '0;
        shQ[i]    <= '0;
        idQ[i]    <= '0;
        attrQ[i]  <= '0;
      end else if (wrVec[i]) begin
        validQ[i] <= 1'b1;
        globQ[i]  <= insGlobal;
        vpnQ[i]   <= insVpn;
        pfnQ[i]   <= insPfn;
        shQ[i]    <= insShift;
        idQ[i]    <= insId;
        attrQ[i]  <= insAttr;
      end else if (clrVec[i]) begin
        validQ[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    lkIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) lkIdx = IDX_W'(i);
    end
  end

  logic [VA_W-1:0] offMask;
  assign lkHit   = |lkMatch;
  assign offMask = (VA_W'(1) << shQ[lkIdx]) - VA_W'(1);
  assign lkPa    = (pfnQ[lkIdx] << shQ[lkIdx]) | PA_W'(lkVa & offMask);
  assign lkAttr  = attrQ[lkIdx];

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrVec)); // R1
  AST_HIT_IS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lkHit |-> validQ[lkIdx]); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrAll && !stb.doWrite) |=> validQ == '0); // R5
  AST_INSERT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    stb.doWrite |=> validQ[$past(wrIdx)]); // R9
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int ID_W    = 8,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int SHIFT_W = $clog2(VA_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkReq,
  input  logic [VA_W-1:0]    lkVa,
  input  logic [ID_W-1:0]    lkId,
  output logic               lkHit,
  output logic [IDX_W-1:0]   lkIdx,
  output logic [PA_W-1:0]    lkPa,
  output logic [9:0]         lkAttr,
  input  logic               insValid,
  input  logic [VA_W-1:0]    insVpn,
  input  logic [PA_W-1:0]    insPfn,
  input  logic [SHIFT_W-1:0] insShift,
  input  logic [ID_W-1:0]    insId,
  input  logic               insGlobal,
  input  logic [9:0]         insAttr,
  input  logic               mntValid,
  input  logic [1:0]         mntOp,
  input  logic [VA_W-1:0]    mntAddr,
  input  logic [ID_W-1:0]    mntId
);
  tlb_strobe_t      stb;
  logic [IDX_W-1:0] victimPtr;

  tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lkReq(lkReq), .lkHit(lkHit), .lkIdx(lkIdx),
    .insValid(insValid), .mntValid(mntValid), .mntOp(mntOp),
    .stb(stb), .victimPtr(victimPtr)
  );

  tlb_dpath #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .ID_W(ID_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(victimPtr),
    .lkVa(lkVa), .lkId(lkId), .lkHit(lkHit), .lkIdx(lkIdx), .lkPa(lkPa),
    .lkAttr(lkAttr), .insVpn(insVpn), .insPfn(insPfn), .insShift(insShift),
    .insId(insId), .insGlobal(insGlobal), .insAttr(insAttr),
    .mntAddr(mntAddr), .mntId(mntId)
  );
endmodule

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkReq = 1'b0;
  logic [31:0] lkVa = '0;
  logic [7:0]  lkId = '0;
  logic        lkHit;
  logic [3:0]  lkIdx;
  logic [31:0] lkPa;
  logic [9:0]  lkAttr;
  logic        insValid = 1'b0;
  logic [31:0] insVpn = '0;
  logic [31:0] insPfn = '0;
  logic [4:0]  insShift = '0;
  logic [7:0]  insId = '0;
  logic        insGlobal = 1'b0;
  logic [9:0]  insAttr = '0;
  logic        mntValid = 1'b0;
  logic [1:0]  mntOp = '0;
  logic [31:0] mntAddr = '0;
  logic [7:0]  mntId = '0;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  tlb_fa u0 (.*);

  // {va, id, hit, idx, pa, attr}
  localparam logic [86:0] VEC [6] = '{
    {32'h12345678, 8'd3, 1'b1, 4'd0, 32'h00abc678, 10'h155},
    {32'h12345678, 8'd7, 1'b1, 4'd3, 32'h22222678, 10'h3c3},
    {32'h456abcde, 8'd9, 1'b1, 4'd1, 32'h07fabcde, 10'h2aa},
    {32'h40000ffc, 8'd3, 1'b1, 4'd2, 32'h11111ffc, 10'h001},
    {32'h40000ffc, 8'd4, 1'b0, 4'd0, 32'h0,        10'h0},
    {32'h12346000, 8'd3, 1'b0, 4'd0, 32'h0,        10'h0}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic insert(input logic [31:0] vpn, input logic [31:0] pfn,
                        input logic [4:0] sh, input logic [7:0] id,
                        input logic glob, input logic [9:0] attr);
    @(negedge clk);
    insValid = 1'b1; insVpn = vpn; insPfn = pfn; insShift = sh;
    insId = id; insGlobal = glob; insAttr = attr;
    @(posedge clk); #1;
    insValid = 1'b0;
  endtask

  task automatic maint(input logic [1:0] op, input logic [31:0] addr,
                       input logic [7:0] id);
    @(negedge clk);
    mntValid = 1'b1; mntOp = op; mntAddr = addr; mntId = id;
    @(posedge clk); #1;
    mntValid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] id,
                      input logic req, input logic expHit,
                      input logic [3:0] expIdx, input string tag);
    @(negedge clk);
    lkVa = va; lkId = id; lkReq = req;
    #1;
    check(lkHit == expHit, tag, 32'(lkHit), 32'(expHit));
    if (expHit) check(lkIdx == expIdx, tag, 32'(lkIdx), 32'(expIdx));
    @(posedge clk); #1;
    lkReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10: empty after reset
    look(32'h0, 8'd0, 1'b0, 1'b0, 4'd0, "R10 no hit after reset");
    look(32'h12345678, 8'd3, 1'b0, 1'b0, 4'd0, "R10 no hit after reset");

    // R1: fill slots 0..4 in order
    insert(32'h12345, 32'h00abc, 5'd12, 8'd3, 1'b0, 10'h155);
    insert(32'h456,   32'h7f,    5'd20, 8'd5, 1'b1, 10'h2aa);
    insert(32'h40000, 32'h11111, 5'd12, 8'd3, 1'b0, 10'h001);
    insert(32'h12345, 32'h22222, 5'd12, 8'd7, 1'b0, 10'h3c3);
    insert(32'h12345, 32'h33333, 5'd12, 8'd3, 1'b0, 10'h0f0);

    // R2 R3: vector table
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      lkVa = VEC[k][86:55]; lkId = VEC[k][54:47]; lkReq = 1'b0;
      #1;
      check(lkHit == VEC[k][46], "R2 hit", 32'(lkHit), 32'(VEC[k][46]));
      if (VEC[k][46]) begin
        check(lkIdx == VEC[k][45:42], "R2 index lowest wins", 32'(lkIdx), 32'(VEC[k][45:42]));
        check(lkPa == VEC[k][41:10], "R3 physical address", lkPa, VEC[k][41:10]);
        check(lkAttr == VEC[k][9:0], "R2 attributes", 32'(lkAttr), 32'(VEC[k][9:0]));
      end
    end

    // R1: wrap the pointer
    for (int k = 0; k < 11; k++)
      insert(32'h50000 + 32'(k), 32'h1000 + 32'(k), 5'd12, 8'd1, 1'b0, 10'h0);
    insert(32'h60000, 32'h0beef, 5'd12, 8'd1, 1'b0, 10'h0);
    look(32'h60000000, 8'd1, 1'b0, 1'b1, 4'd0, "R1 wrap to slot 0");
    look(32'h12345678, 8'd3, 1'b0, 1'b1, 4'd4, "R2 surviving duplicate");

    // R4: requested hit on pointed slot 1 skips it
    look(32'h456abcde, 8'd9, 1'b1, 1'b1, 4'd1, "R4 hit pointed slot");
    insert(32'h61000, 32'h0aaaa, 5'd12, 8'd1, 1'b0, 10'h0);
    look(32'h61000000, 8'd1, 1'b0, 1'b1, 4'd2, "R4 pointer skipped");
    // R4: hit elsewhere does not move the pointer (now 3)
    look(32'h60000000, 8'd1, 1'b1, 1'b1, 4'd0, "R4 hit other slot");
    insert(32'h62000, 32'h0bbbb, 5'd12, 8'd1, 1'b0, 10'h0);
    look(32'h62000000, 8'd1, 1'b0, 1'b1, 4'd3, "R4 pointer held");

    // R6: by identifier
    maint(2'd1, 32'h0, 8'd3);
    look(32'h12345678, 8'd3, 1'b0, 1'b0, 4'd0, "R6 id flush");
    look(32'h456abcde, 8'd5, 1'b0, 1'b1, 4'd1, "R6 other id kept");

    // R7: by address, identifier ignored
    maint(2'd2, 32'h45612345, 8'd99);
    look(32'h456abcde, 8'd5, 1'b0, 1'b0, 4'd0, "R7 address flush");
    look(32'h60000000, 8'd1, 1'b0, 1'b1, 4'd0, "R7 other page kept");

    // R8: by address and identifier, two copies removed
    insert(32'h70000, 32'h0a0a0, 5'd12, 8'd2, 1'b0, 10'h0);
    insert(32'h70000, 32'h0b0b0, 5'd12, 8'd2, 1'b0, 10'h0);
    insert(32'h70000, 32'h0a0a0, 5'd12, 8'd8, 1'b0, 10'h0);
    maint(2'd3, 32'h70000123, 8'd2);
    look(32'h70000123, 8'd2, 1'b0, 1'b0, 4'd0, "R8 all copies flushed");
    @(negedge clk);
    lkVa = 32'h70000123; lkId = 8'd8; #1;
    check(lkHit && lkIdx == 4'd6, "R8 other id kept", 32'(lkIdx), 32'd6);
    check(lkPa == 32'h0a0a0123, "R3 page 4K", lkPa, 32'h0a0a0123);

    // R9: lookup during maintenance sees old contents
    @(negedge clk);
    mntValid = 1'b1; mntOp = 2'd1; mntId = 8'd8;
    lkVa = 32'h70000123; lkId = 8'd8; #1;
    check(lkHit && lkIdx == 4'd6, "R9 lookup sees pre-op", 32'(lkHit), 32'd1);
    @(posedge clk); #1;
    mntValid = 1'b0;
    look(32'h70000123, 8'd8, 1'b0, 1'b0, 4'd0, "R9 flushed after edge");

    // R9 R5: insert during invalidate-all (pointer 7)
    @(negedge clk);
    mntValid = 1'b1; mntOp = 2'd0;
    insValid = 1'b1; insVpn = 32'h80000; insPfn = 32'h12121; insShift = 5'd12;
    insId = 8'd1; insGlobal = 1'b0; insAttr = 10'h0;
    @(posedge clk); #1;
    mntValid = 1'b0; insValid = 1'b0;
    look(32'h80000abc, 8'd1, 1'b0, 1'b1, 4'd7, "R9 insert survives flush");
    look(32'h60000000, 8'd1, 1'b0, 1'b0, 4'd0, "R5 all flushed");
    insert(32'h90000, 32'h00001, 5'd12, 8'd1, 1'b0, 10'h0);
    look(32'h90000000, 8'd1, 1'b0, 1'b1, 4'd0, "R5 pointer reset");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule